// File: doc/BRIEF.md
# Gated Dual Timer/Counter

This block holds two identical up-counters, unit 0 and unit 1. Each unit is split into a low byte and a high byte. It advances either on a one-cycle internal `tick` strobe or on a falling edge of its own external count pin. A software run bit starts and stops each unit. A per-unit gate option also requires that unit's gate pin to be high before any counting can happen. When a unit wraps, it raises its overflow flag. The flag stays set until an external clear strobe or a register write lowers it.

Each unit has four count formats:
- a 13-bit count (a 5-bit prescaler in the low byte carrying into the high byte);
- a plain 16-bit count;
- an 8-bit count that reloads from the high byte;
- a frozen setting.

Software uses a simple write port and a combinational read port for the control byte, the configuration byte and the four count bytes. An interrupt controller uses the overflow outputs and the per-unit clear strobes.

Each unit runs a four-state machine: IDLE (run bit low), WAIT (running but the gate pin is low), RUN (counting allowed) and HALT (frozen format selected). The state register follows one rule every cycle. HALT is taken whenever the frozen format is selected. Otherwise IDLE is taken when the run bit is low, WAIT when the gate option is on and the synchronized gate pin is low, and RUN in all other cases. The named transitions are: start (IDLE to RUN or WAIT), stop (any to IDLE), gate-close (RUN to WAIT), gate-open (WAIT to RUN), freeze (any to HALT) and thaw (HALT to IDLE, WAIT or RUN). A count event is accepted only during a cycle in which the state register holds RUN.

Top module: `dual_tmr_unit`

## Requirements
- R1: After reset, every register reads 0, both overflow outputs are 0 and all state machines are in IDLE.
- R2: The register addresses are:
  - 0 is control: bit 7 = unit 1 flag, bit 6 = unit 1 run, bit 5 = unit 0 flag, bit 4 = unit 0 run, bits 3:0 read 0 and ignore writes.
  - 1 is configuration: bits 7:4 = unit 1, bits 3:0 = unit 0. Within each nibble, bit 3 = gate option, bit 2 = external source, bits 1:0 = format.
  - 2 and 3 are unit 0 low and high bytes; 4 and 5 are unit 1 low and high bytes.
  - 6 and 7 read 0.
  - `rd_data` is combinational from `rd_addr`.
- R3: With the run bit low, a unit's count does not change. A change of the run bit reaches the state register one clock after the write.
- R4: With the gate option set, a running unit counts only while its gate pin, seen through the synchronizer, is high.
- R5: With external source clear, a unit counts once per cycle in which `tick` is high. With it set, `tick` is ignored and the unit counts once per high-to-low transition of its count pin; steady levels and rising transitions do not count.
- R6: Format 1 is a 16-bit count that wraps from FFFF to 0000 and sets the flag.
- R7: Format 0 increments low bits 4:0 and carries into the high byte. Low bits 7:5 are never changed by counting. Passing from high FF, low 1F sets the flag.
- R8: Format 2 increments the low byte. From FF it reloads the low byte with the high byte and sets the flag. Counting never alters the high byte.
- R9: Format 3 holds both count bytes.
- R10: Flag priority: an overflow set wins over the clear strobe, and the clear strobe wins over a control-register write. Each overflow output mirrors its flag.
- R11: A write to either count byte of a unit in the same cycle as a count event stores the written value and discards that event for the unit.
- R12: The two units are independent. Each uses only its own configuration nibble, control bits, pins and clear strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Internal count strobe |
| cnt_pin | input | 2 | External count pins, one per unit |
| gate_pin | input | 2 | Gate pins, one per unit |
| ovf_clr | input | 2 | Per-unit flag clear strobes |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data |
| ovf | output | 2 | Overflow flags |

## Verification
The hardest situation to reach is one where several things land in the same cycle: an overflow, a clear strobe, a control write and a count-byte write. A related hard case is an external edge or gate change arriving through the synchronizer while the state register is still catching up.

Directed cases handle the known collisions:
- load FF values, then fire a single `tick` together with a clear, checking that the flag stays set;
- write a count byte in the cycle of a `tick`, checking that the count event is dropped.

A long random phase then biases count writes towards FF and run writes towards 1. It toggles the pins at a low rate. Every cycle it compares one randomly chosen register and both flags against a cycle-level model that the bench builds from the requirements.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
    localparam int DW        = 8;
    localparam int AW        = 3;
    localparam int NUM_UNITS = 2;
    localparam int PRE_W     = 5;

    localparam logic [AW-1:0] ADR_CTRL = 3'd0;
    localparam logic [AW-1:0] ADR_CFG  = 3'd1;
    localparam int ADR_CNT_BASE = 2;

    localparam int RUN_POS  = 4;
    localparam int FLAG_POS = 5;
    localparam int CFG_W    = 4;
    localparam int GATE_BIT = 3;
    localparam int EXT_BIT  = 2;

    typedef enum logic [1:0] {
        MD_13     = 2'd0,
        MD_16     = 2'd1,
        MD_RELOAD = 2'd2,
        MD_HALT   = 2'd3
    } tmode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2,
        ST_HALT = 2'd3
    } ustate_e;

    function automatic logic [AW-1:0] lo_adr(input int u);
        return AW'(ADR_CNT_BASE + 2 * u);
    endfunction

    function automatic logic [AW-1:0] hi_adr(input int u);
        return AW'(ADR_CNT_BASE + 2 * u + 1);
    endfunction
endpackage

// File: rtl/dtmr_sync.sv
module dtmr_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr <= {STAGES{RST_VAL}};
        end else begin
            sr <= {sr[STAGES-2:0], d};
        end
    end

    assign q = sr[STAGES-1];
endmodule

// File: rtl/dtmr_unit.sv
module dtmr_unit
    import dtmr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cnt_pin,
    input  logic             gate_pin,
    input  logic             run,
    input  logic [CFG_W-1:0] cfg,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [DW-1:0]    wdata,
    input  logic             flag_wr,
    input  logic             flag_wval,
    input  logic             flag_clr,
    output logic [DW-1:0]    lo_q,
    output logic [DW-1:0]    hi_q,
    output logic             flag_q
);
    localparam logic [PRE_W-1:0] PRE_ONE  = PRE_W'(1);
    localparam logic [DW-1:0]    BYTE_ONE = DW'(1);
    localparam logic [2*DW-1:0]  WORD_ONE = (2 * DW)'(1);

    tmode_e  md;
    ustate_e st_q, st_d;
    logic    cnt_s, cnt_prev, gate_s, fall;
    logic    halt_req, hold_req, step, bump, wrap;
    logic [DW-1:0] lo_inc, hi_inc;

    assign md = tmode_e'(cfg[1:0]);

    dtmr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_cnt_sync (
        .clk(clk), .rst_n(rst_n), .d(cnt_pin), .q(cnt_s)
    );
    dtmr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_gate_sync (
        .clk(clk), .rst_n(rst_n), .d(gate_pin), .q(gate_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_prev <= 1'b1;
        else        cnt_prev <= cnt_s;
    end

    assign fall     = cnt_prev & ~cnt_s;
    assign halt_req = (md == MD_HALT);
    assign hold_req = cfg[GATE_BIT] & ~gate_s;

    // next-state: start, stop, gate-close, gate-open, freeze, thaw
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (halt_req)      st_d = ST_HALT;
                else if (run)      st_d = hold_req ? ST_WAIT : ST_RUN;
            end
            ST_WAIT: begin
                if (halt_req)      st_d = ST_HALT;
                else if (!run)     st_d = ST_IDLE;
                else if (!hold_req) st_d = ST_RUN;
            end
            ST_RUN: begin
                if (halt_req)      st_d = ST_HALT;
                else if (!run)     st_d = ST_IDLE;
                else if (hold_req) st_d = ST_WAIT;
            end
            ST_HALT: begin
                if (!halt_req) begin
                    if (!run)          st_d = ST_IDLE;
                    else if (hold_req) st_d = ST_WAIT;
                    else               st_d = ST_RUN;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // output process: count event acceptance
    always_comb begin
        step = 1'b0;
        unique case (st_q)
            ST_RUN:                     step = cfg[EXT_BIT] ? fall : tick;
            ST_IDLE, ST_WAIT, ST_HALT:  step = 1'b0;
        endcase
    end

    always_comb begin
        lo_inc = lo_q;
        hi_inc = hi_q;
        wrap   = 1'b0;
        unique case (md)
            MD_13: begin
                lo_inc[PRE_W-1:0] = lo_q[PRE_W-1:0] + PRE_ONE;
                if (&lo_q[PRE_W-1:0]) begin
                    hi_inc = hi_q + BYTE_ONE;
                    wrap   = &hi_q;
                end
            end
            MD_16: begin
                {hi_inc, lo_inc} = {hi_q, lo_q} + WORD_ONE;
                wrap = &{hi_q, lo_q};
            end
            MD_RELOAD: begin
                if (&lo_q) begin
                    lo_inc = hi_q;
                    wrap   = 1'b1;
                end else begin
                    lo_inc = lo_q + BYTE_ONE;
                end
            end
            MD_HALT: begin
                wrap = 1'b0;
            end
        endcase
    end

    assign bump = step & ~wr_lo & ~wr_hi;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q   <= '0;
            hi_q   <= '0;
            flag_q <= 1'b0;
        end else begin
            if (wr_lo)     lo_q <= wdata;
            else if (bump) lo_q <= lo_inc;
            if (wr_hi)     hi_q <= wdata;
            else if (bump) hi_q <= hi_inc;
            if (bump && wrap)  flag_q <= 1'b1;
            else if (flag_clr) flag_q <= 1'b0;
            else if (flag_wr)  flag_q <= flag_wval;
        end
    end
endmodule

// File: rtl/dual_tmr_unit.sv
module dual_tmr_unit
    import dtmr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic [NUM_UNITS-1:0] cnt_pin,
    input  logic [NUM_UNITS-1:0] gate_pin,
    input  logic [NUM_UNITS-1:0] ovf_clr,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_addr,
    input  logic [DW-1:0]        wr_data,
    input  logic [AW-1:0]        rd_addr,
    output logic [DW-1:0]        rd_data,
    output logic [NUM_UNITS-1:0] ovf
);
    localparam int NU = NUM_UNITS;

    logic [NU-1:0]         run_q;
    logic [DW-1:0]         mode_q;
    logic [NU-1:0][DW-1:0] lo_v, hi_v;
    logic [NU-1:0]         wr_lo, wr_hi;
    logic                  ctl_wr, cfg_wr;

    assign ctl_wr = wr_en && (wr_addr == ADR_CTRL);
    assign cfg_wr = wr_en && (wr_addr == ADR_CFG);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      mode_q <= '0;
        else if (cfg_wr) mode_q <= wr_data;
    end

    for (genvar u = 0; u < NU; u++) begin : g_unit
        assign wr_lo[u] = wr_en && (wr_addr == lo_adr(u));
        assign wr_hi[u] = wr_en && (wr_addr == hi_adr(u));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      run_q[u] <= 1'b0;
            else if (ctl_wr) run_q[u] <= wr_data[RUN_POS + 2*u];
        end

        dtmr_unit #(.SYNC_STAGES(SYNC_STAGES)) i_unit (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (tick),
            .cnt_pin   (cnt_pin[u]),
            .gate_pin  (gate_pin[u]),
            .run       (run_q[u]),
            .cfg       (mode_q[CFG_W*u +: CFG_W]),
            .wr_lo     (wr_lo[u]),
            .wr_hi     (wr_hi[u]),
            .wdata     (wr_data),
            .flag_wr   (ctl_wr),
            .flag_wval (wr_data[FLAG_POS + 2*u]),
            .flag_clr  (ovf_clr[u]),
            .lo_q      (lo_v[u]),
            .hi_q      (hi_v[u]),
            .flag_q    (ovf[u])
        );
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADR_CTRL) begin
            for (int u = 0; u < NU; u++) begin
                rd_data[RUN_POS + 2*u]  = run_q[u];
                rd_data[FLAG_POS + 2*u] = ovf[u];
            end
        end else if (rd_addr == ADR_CFG) begin
            rd_data = mode_q;
        end else begin
            for (int u = 0; u < NU; u++) begin
                if (rd_addr == lo_adr(u)) rd_data = lo_v[u];
                if (rd_addr == hi_adr(u)) rd_data = hi_v[u];
            end
        end
    end
endmodule

// File: rtl/dtmr_chk.sv
module dtmr_chk
    import dtmr_pkg::*;
(
    input logic                        clk,
    input logic                        rst_n,
    input logic [NUM_UNITS-1:0]        run_q,
    input logic [DW-1:0]               mode_q,
    input logic [NUM_UNITS-1:0][DW-1:0] lo_v,
    input logic [NUM_UNITS-1:0][DW-1:0] hi_v,
    input logic [NUM_UNITS-1:0]        wr_lo,
    input logic [NUM_UNITS-1:0]        wr_hi,
    input logic [NUM_UNITS-1:0]        ovf
);
    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_chk
        // R3
        run_low_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!$past(run_q[u]) && !wr_lo[u] && !wr_hi[u]) |=> ($stable(lo_v[u]) && $stable(hi_v[u])));

        // R9
        halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q[CFG_W*u +: 2] == 2'd3 && !wr_lo[u] && !wr_hi[u]) |=> ($stable(lo_v[u]) && $stable(hi_v[u])));

        // R8
        reload_hi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q[CFG_W*u +: 2] == 2'd2 && !wr_hi[u]) |=> $stable(hi_v[u]));

        // R7
        pre_top_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q[CFG_W*u +: 2] == 2'd0 && !wr_lo[u]) |=> $stable(lo_v[u][DW-1:PRE_W]));

        // R6
        wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ({hi_v[u], lo_v[u]} == '0 && $past({hi_v[u], lo_v[u]}) == '1
             && $past(mode_q[CFG_W*u +: 2]) == 2'd1 && !$past(wr_lo[u] | wr_hi[u])) |-> ovf[u]);
    end
endmodule

bind dual_tmr_unit dtmr_chk i_dtmr_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_q  (run_q),
    .mode_q (mode_q),
    .lo_v   (lo_v),
    .hi_v   (hi_v),
    .wr_lo  (wr_lo),
    .wr_hi  (wr_hi),
    .ovf    (ovf)
);

// File: tb/test_dual_tmr_unit.sv
module test_dual_tmr_unit;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [1:0] cnt_pin = 2'b11;
    logic [1:0] gate_pin = 2'b00;
    logic [1:0] ovf_clr = 2'b00;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [1:0] ovf;

    int n_chk = 0;
    int n_fail = 0;
    bit cmp_en = 1'b0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_tmr_unit i_dual_tmr_unit (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_pin(cnt_pin),
        .gate_pin(gate_pin), .ovf_clr(ovf_clr), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .ovf(ovf)
    );

    // ---------------- reference model from the requirements ----------------
    logic [1:0] m_run, m_ovf;
    logic [7:0] m_mode;
    logic [7:0] m_lo [2];
    logic [7:0] m_hi [2];
    logic [1:0] m_cs [2];
    logic [1:0] m_gs [2];
    logic       m_cp [2];
    logic [1:0] m_st [2];   // 0 idle, 1 wait, 2 run, 3 halt

    function automatic logic [16:0] nxt(input logic [1:0] md, input logic [7:0] hi, input logic [7:0] lo);
        logic [15:0] v;
        case (md)
            2'd0: begin
                if (lo[4:0] == 5'h1F) return {(hi == 8'hFF), hi + 8'd1, lo[7:5], 5'd0};
                else                  return {1'b0, hi, lo[7:5], lo[4:0] + 5'd1};
            end
            2'd1: begin
                v = {hi, lo} + 16'd1;
                return {(v == 16'd0), v};
            end
            2'd2: return (lo == 8'hFF) ? {1'b1, hi, hi} : {1'b0, hi, lo + 8'd1};
            default: return {1'b0, hi, lo};
        endcase
    endfunction

    logic [3:0]  t_md;
    logic        t_stp, t_wlo, t_whi, t_ov;
    logic [16:0] t_r;
    logic [7:0]  t_lo, t_hi;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run <= '0; m_ovf <= '0; m_mode <= '0;
            for (int u = 0; u < 2; u++) begin
                m_lo[u] <= '0; m_hi[u] <= '0; m_cs[u] <= 2'b11;
                m_gs[u] <= 2'b00; m_cp[u] <= 1'b1; m_st[u] <= 2'd0;
            end
        end else begin
            for (int u = 0; u < 2; u++) begin
                t_md = m_mode[4*u +: 4];
                m_st[u] <= (t_md[1:0] == 2'd3) ? 2'd3 : (!m_run[u]) ? 2'd0 :
                           (t_md[3] && !m_gs[u][1]) ? 2'd1 : 2'd2;
                t_stp = (m_st[u] == 2'd2) && (t_md[2] ? (m_cp[u] && !m_cs[u][1]) : tick);
                t_wlo = wr_en && (wr_addr == 3'(2 + 2*u));
                t_whi = wr_en && (wr_addr == 3'(3 + 2*u));
                t_r   = nxt(t_md[1:0], m_hi[u], m_lo[u]);
                t_lo  = m_lo[u]; t_hi = m_hi[u]; t_ov = 1'b0;
                if (t_stp && !t_wlo && !t_whi) begin
                    t_lo = t_r[7:0]; t_hi = t_r[15:8]; t_ov = t_r[16];
                end
                if (t_wlo) t_lo = wr_data;
                if (t_whi) t_hi = wr_data;
                m_lo[u] <= t_lo;
                m_hi[u] <= t_hi;
                if (t_ov)                             m_ovf[u] <= 1'b1;
                else if (ovf_clr[u])                  m_ovf[u] <= 1'b0;
                else if (wr_en && wr_addr == 3'd0)    m_ovf[u] <= wr_data[5 + 2*u];
                if (wr_en && wr_addr == 3'd0)         m_run[u] <= wr_data[4 + 2*u];
                m_cs[u] <= {m_cs[u][0], cnt_pin[u]};
                m_cp[u] <= m_cs[u][1];
                m_gs[u] <= {m_gs[u][0], gate_pin[u]};
            end
            if (wr_en && wr_addr == 3'd1) m_mode <= wr_data;
        end
    end

    function automatic logic [7:0] exp_rd(input logic [2:0] a);
        case (a)
            3'd0: return {m_ovf[1], m_run[1], m_ovf[0], m_run[0], 4'b0000};
            3'd1: return m_mode;
            3'd2: return m_lo[0];
            3'd3: return m_hi[0];
            3'd4: return m_lo[1];
            3'd5: return m_hi[1];
            default: return 8'h00;
        endcase
    endfunction

    function automatic string req_of(input logic [2:0] a);
        case (a)
            3'd0: return "R10";
            3'd2, 3'd3, 3'd4, 3'd5: return "R11";
            default: return "R2";
        endcase
    endfunction

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en && !done) begin
            chk(rd_data, exp_rd(rd_addr), req_of(rd_addr));
            chk({6'b0, ovf}, {6'b0, m_ovf}, "R10");
        end
    end

    // ---------------- directed helpers ----------------
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); #1; wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); #1; wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic one_tick();
        @(negedge clk); #1; tick = 1'b1;
        @(negedge clk); #1; tick = 1'b0;
    endtask

    task automatic chk_rd(input logic [2:0] a, input logic [7:0] exp, input string req);
        @(negedge clk); #1; rd_addr = a; #1;
        chk(rd_data, exp, req);
    endtask

    task automatic chk_ovf(input logic [1:0] exp, input string req);
        @(negedge clk); #2;
        chk({6'b0, ovf}, {6'b0, exp}, req);
    endtask

    task automatic pulse_clr(input logic [1:0] m);
        @(negedge clk); #1; ovf_clr = m;
        @(negedge clk); #1; ovf_clr = 2'b00;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20417));
        repeat (5) @(negedge clk);
        #1 rst_n = 1'b1;
        cmp_en = 1'b1;

        // R1 reset state
        for (int a = 0; a < 6; a++) chk_rd(3'(a), 8'h00, "R1");
        chk_ovf(2'b00, "R1");

        // R6 16-bit wrap
        wr(3'd1, 8'h01); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF); wr(3'd0, 8'h10);
        idle(4); one_tick();
        chk_rd(3'd2, 8'h00, "R6"); chk_rd(3'd3, 8'h00, "R6");
        chk_ovf(2'b01, "R6");
        // R10 clear strobe
        pulse_clr(2'b01);
        chk_ovf(2'b00, "R10");

        // R10 overflow beats clear strobe
        wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
        @(negedge clk); #1; tick = 1'b1; ovf_clr = 2'b01;
        @(negedge clk); #1; tick = 1'b0; ovf_clr = 2'b00;
        chk_ovf(2'b01, "R10");
        wr(3'd0, 8'h10);
        chk_ovf(2'b00, "R10");
        wr(3'd0, 8'h30);
        chk_ovf(2'b01, "R10");
        pulse_clr(2'b01);

        // R11 write beats count event
        @(negedge clk); #1; tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd2; wr_data = 8'h40;
        @(negedge clk); #1; tick = 1'b0; wr_en = 1'b0;
        chk_rd(3'd2, 8'h40, "R11"); chk_rd(3'd3, 8'h00, "R11");

        // R7 13-bit format
        wr(3'd1, 8'h00); wr(3'd2, 8'h1F); wr(3'd3, 8'h12);
        idle(2); one_tick();
        chk_rd(3'd2, 8'h00, "R7"); chk_rd(3'd3, 8'h13, "R7");
        wr(3'd2, 8'hFF); wr(3'd3, 8'hFF); one_tick();
        chk_rd(3'd2, 8'hE0, "R7"); chk_rd(3'd3, 8'h00, "R7");
        chk_ovf(2'b01, "R7");
        pulse_clr(2'b01);

        // R8 reload format
        wr(3'd1, 8'h02); wr(3'd3, 8'h80); wr(3'd2, 8'hFE);
        idle(2); one_tick();
        chk_rd(3'd2, 8'hFF, "R8");
        one_tick();
        chk_rd(3'd2, 8'h80, "R8"); chk_rd(3'd3, 8'h80, "R8");
        chk_ovf(2'b01, "R8");
        pulse_clr(2'b01);

        // R9 frozen format
        wr(3'd1, 8'h03); wr(3'd2, 8'h55); idle(2); one_tick();
        chk_rd(3'd2, 8'h55, "R9");

        // R3 run bit
        wr(3'd1, 8'h01); wr(3'd0, 8'h00); idle(3);
        wr(3'd2, 8'h10); wr(3'd3, 8'h00); one_tick();
        chk_rd(3'd2, 8'h10, "R3");
        wr(3'd0, 8'h10); idle(3); one_tick();
        chk_rd(3'd2, 8'h11, "R3");

        // R4 gate option
        wr(3'd1, 8'h09); idle(5); one_tick();
        chk_rd(3'd2, 8'h11, "R4");
        @(negedge clk); #1; gate_pin[0] = 1'b1;
        idle(5); one_tick();
        chk_rd(3'd2, 8'h12, "R4");

        // R5 external source
        wr(3'd1, 8'h05); idle(3);
        @(negedge clk); #1; tick = 1'b1;
        idle(6);
        @(negedge clk); #1; tick = 1'b0;
        chk_rd(3'd2, 8'h12, "R5");
        @(negedge clk); #1; cnt_pin[0] = 1'b0;
        idle(6);
        chk_rd(3'd2, 8'h13, "R5");
        @(negedge clk); #1; cnt_pin[0] = 1'b1;
        idle(6);
        chk_rd(3'd2, 8'h13, "R5");

        // R12 unit 1 independent
        wr(3'd0, 8'h40); wr(3'd1, 8'h10); wr(3'd4, 8'h07);
        idle(3); one_tick();
        chk_rd(3'd4, 8'h08, "R12"); chk_rd(3'd2, 8'h13, "R12");

        // R2 register map
        wr(3'd0, 8'h4F);
        chk_rd(3'd0, 8'h40, "R2"); chk_rd(3'd1, 8'h10, "R2");
        chk_rd(3'd6, 8'h00, "R2"); chk_rd(3'd7, 8'h00, "R2");

        // random phase, compared every cycle against the model
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk); #1;
            tick = ($urandom % 3) != 0;
            if ($urandom % 6 == 0)  cnt_pin[0] = ~cnt_pin[0];
            if ($urandom % 6 == 0)  cnt_pin[1] = ~cnt_pin[1];
            if ($urandom % 25 == 0) gate_pin[0] = ~gate_pin[0];
            if ($urandom % 25 == 0) gate_pin[1] = ~gate_pin[1];
            ovf_clr = ($urandom % 16 == 0) ? 2'($urandom) : 2'b00;
            wr_en   = ($urandom % 6) == 0;
            wr_addr = 3'($urandom % 6);
            wr_data = 8'($urandom);
            if (wr_addr == 3'd0 && ($urandom % 4) != 0) wr_data = wr_data | 8'h50;
            if (wr_addr >= 3'd2 && ($urandom % 2) != 0) wr_data = 8'hFF;
            rd_addr = 3'($urandom % 8);
        end
        @(negedge clk); #1; wr_en = 1'b0; tick = 1'b0;
        idle(2);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule